// File: doc/BRIEF.md
# Timer Run-Control and Event-Flag Register

This block is the 8-bit control and status register of a down-counting timer. It sits on a simple register bus (select, write strobe, write data, read data) clocked by the system clock. A count-source tick pulse arrives in the same clock domain. Software writes a start bit to ask the timer to run or halt. The request waits until the next count-source tick, and on that tick the read-only run-status bit and the count-enable output change together. A forced-stop bit halts the timer at once, cancels any pending start and always reads as zero.

Two sticky event flags record activity from the timer datapath. One records a counter underflow. The other records edge-measurement completion, and the measurement-mode input decides which event pulse sets it. Software clears either flag by writing 0 to its bit and cannot set it. When a hardware event and a software clear land in the same cycle, the event wins. The counter, the reload path and the input edge detection are outside this block and reach it only as pulses and a mode code.

Top module: `tmr_ctl_reg`

## Requirements
- R1: After reset the register reads 0x00 and count_en is 0. Bits 7, 6 and 3 always read 0, and writing 1 to them changes nothing.
- R2: Bit 2 is the forced-stop bit and always reads 0, including in the cycle after a 1 is written to it.
- R3: Bit 5 is the underflow flag. An evt_underflow pulse sets it. A register write with bit 5 = 0 clears it, and a write with bit 5 = 1 leaves it unchanged.
- R4: Bit 4 is the edge flag. When meas_mode = 2'b01 (width), evt_width_done sets it. When meas_mode = 2'b10 (period), evt_edge_in sets it. Any other pairing of mode and pulse leaves it unchanged. A write with bit 4 = 0 clears it.
- R5: When an event pulse and a clearing write to its flag occur in the same cycle, the flag ends up set.
- R6: Bit 0 (start) reads back the last value written to it. Bit 1 (run status) and count_en take the start value only on a cycle in which src_tick = 1. A tick in the same cycle as the write does not apply that write.
- R7: Bit 1 is read-only: writing it has no effect on status or count_en.
- R8: A write with bit 2 = 1 clears start, status and count_en in that cycle with no tick needed. It also overrides a 1 written to bit 0 in the same write.
- R9: A forced stop issued while a start request is pending cancels the request, so later ticks leave status and count_en at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Address decode hit for this register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: {0,0,underflow,edge,0,0,status,start} |
| src_tick | input | 1 | One-cycle count-source pulse |
| evt_underflow | input | 1 | Counter underflow pulse |
| evt_width_done | input | 1 | Active-width measurement complete pulse |
| evt_edge_in | input | 1 | Selected input edge pulse |
| meas_mode | input | 2 | 00 none, 01 pulse width, 10 pulse period, 11 none |
| count_en | output | 1 | Counter enable, equal to the run status |

## Verification
The run control is tried with a start written with no tick, followed by a separate tick. It is also tried with a start written in the same cycle as a tick, and with a stop request followed by a tick. Together these separate "applied on a later tick" from "applied at the write" and from "applied by the coincident tick". The edge flag gets each event pulse under each mode, which shows whether the mode steers the right source. The flags are written with 1 and with 0, with and without a coincident event, which separates clear-only behaviour and set priority from plain write-through. Forced stop is issued while running, while a start is pending, and together with a start bit, which shows whether it acts at once and whether it overrides the start.

// File: rtl/tcr_pkg.sv
// Shared definitions for the timer control register: bit positions that
// software decodes, and the measurement-mode encoding.
package tcr_pkg;
    localparam int BIT_START  = 0;
    localparam int BIT_STATUS = 1;
    localparam int BIT_STOP   = 2;
    localparam int BIT_EDGE   = 4;
    localparam int BIT_UNDF   = 5;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'b00,
        MODE_WIDTH  = 2'b01,
        MODE_PERIOD = 2'b10,
        MODE_RSVD   = 2'b11
    } meas_mode_e;
endpackage

// File: rtl/tcr_sticky_flag.sv
// Sticky event flag. A hardware pulse sets it, and a software clear resets it.
// Assumes: hw_set and sw_clr are single-cycle qualified pulses in the clk domain.
// On a collision the set has priority.
module tcr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_clr,
    output logic q
);
    // Hold the flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (hw_set) q <= 1'b1;
        else if (sw_clr) q <= 1'b0;
    end

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> q);
    a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hw_set) |=> !q);
    a_r3_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && !hw_set) |=> !q);
endmodule

// File: rtl/tcr_edge_src.sv
// Picks which datapath pulse sets the edge flag for the current measurement mode.
// Assumes: meas_mode is quasi-static and both pulses are in the clk domain.
module tcr_edge_src
    import tcr_pkg::*;
(
    input  meas_mode_e mode,
    input  logic       width_done,
    input  logic       edge_in,
    output logic       set_pulse
);
    // Steer the mode-appropriate event onto the set line.
    always_comb begin
        unique case (mode)
            MODE_WIDTH:  set_pulse = width_done;
            MODE_PERIOD: set_pulse = edge_in;
            default:     set_pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcr_run_ctl.sv
// Start/stop sequencing. The start bit holds the software request. The run
// status copies it on a count-source tick. A forced stop clears both at once.
// Assumes: tick is a single-cycle pulse in the clk domain.
module tcr_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_start,
    input  logic wr_stop,
    input  logic tick,
    output logic start_q,
    output logic run_q
);
    // Track the request and apply it to the run status on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            run_q   <= 1'b0;
        end else if (wr_en && wr_stop) begin
            start_q <= 1'b0;
            run_q   <= 1'b0;
        end else begin
            if (wr_en) start_q <= wr_start;
            if (tick)  run_q   <= start_q;
        end
    end

    a_r8_stop_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_stop) |=> (!run_q && !start_q));
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(wr_en && wr_stop)) |=> $stable(run_q));
    a_r6_follow_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(wr_en && wr_stop)) |=> (run_q == $past(start_q)));
endmodule

// File: rtl/tmr_ctl_reg.sv
// Timer control/status register top. It decodes bus writes, drives the run
// control and two event flags, and assembles the read word.
// Assumes: single clock domain and a synchronous active-low reset. The read
// data is combinational from the state and independent of bus_sel.
module tmr_ctl_reg
    import tcr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              src_tick,
    input  logic              evt_underflow,
    input  logic              evt_width_done,
    input  logic              evt_edge_in,
    input  logic [1:0]        meas_mode,
    output logic              count_en
);
    localparam int NFLAG = 2;

    logic             wr_hit;
    logic             start_q, run_q;
    logic             edge_set;
    logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

    // Qualify a register write.
    assign wr_hit = bus_sel && bus_wr;

    tcr_run_ctl u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_hit),
        .wr_start (bus_wdata[BIT_START]),
        .wr_stop  (bus_wdata[BIT_STOP]),
        .tick     (src_tick),
        .start_q  (start_q),
        .run_q    (run_q)
    );

    tcr_edge_src u_esrc (
        .mode       (meas_mode_e'(meas_mode)),
        .width_done (evt_width_done),
        .edge_in    (evt_edge_in),
        .set_pulse  (edge_set)
    );

    // Flag 0 = edge (bit 4), flag 1 = underflow (bit 5).
    assign flag_set = {evt_underflow, edge_set};
    assign flag_clr = {wr_hit && !bus_wdata[BIT_UNDF], wr_hit && !bus_wdata[BIT_EDGE]};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        tcr_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (flag_set[g]),
            .sw_clr (flag_clr[g]),
            .q      (flag_q[g])
        );
    end

    // Assemble the read word; unused and write-only bits read zero.
    always_comb begin
        bus_rdata             = '0;
        bus_rdata[BIT_START]  = start_q;
        bus_rdata[BIT_STATUS] = run_q;
        bus_rdata[BIT_EDGE]   = flag_q[0];
        bus_rdata[BIT_UNDF]   = flag_q[1];
    end

    assign count_en = run_q;

    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7:6] == 2'b00) && !bus_rdata[3]);
    a_r2_stop_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata[BIT_STOP]);
    a_r9_cancel_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_wdata[BIT_STOP]) |=> !count_en);
    a_r4_idle_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((meas_mode == 2'b00 || meas_mode == 2'b11) && !wr_hit && !bus_rdata[BIT_EDGE])
        |=> !bus_rdata[BIT_EDGE]);
endmodule

// File: tb/tmr_ctl_reg_bench.sv
`timescale 1ns/1ps
module tmr_ctl_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       src_tick = 1'b0, evt_underflow = 1'b0, evt_width_done = 1'b0, evt_edge_in = 1'b0;
    logic [1:0] meas_mode = 2'b00;
    logic       count_en;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_ctl_reg u_tmr_ctl_reg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .evt_underflow(evt_underflow), .evt_width_done(evt_width_done),
        .evt_edge_in(evt_edge_in), .meas_mode(meas_mode), .count_en(count_en)
    );

    // Layout: [23]wr [22:15]wdata [14]tick [13]uf [12]wd [11]ei [10:9]mode [8:1]exp_rd [0]exp_cen
    function automatic logic [23:0] mk(input logic w, input logic [7:0] d, input logic t,
                                       input logic u, input logic wd, input logic ei,
                                       input logic [1:0] m, input logic [7:0] er, input logic ec);
        return {w, d, t, u, wd, ei, m, er, ec};
    endfunction

    localparam int NV = 18;
    localparam logic [23:0] VEC [NV] = '{
        mk(1, 8'h01, 0, 0, 0, 0, 2'b00, 8'h01, 0), // R6 start pending
        mk(0, 8'h00, 1, 0, 0, 0, 2'b00, 8'h03, 1), // R6 tick applies
        mk(0, 8'h00, 0, 1, 0, 0, 2'b00, 8'h23, 1), // R3 underflow sets
        mk(1, 8'hE9, 0, 0, 0, 0, 2'b00, 8'h23, 1), // R1/R3 unused bits, write 1 keeps
        mk(1, 8'h01, 0, 0, 0, 0, 2'b00, 8'h03, 1), // R3 write 0 clears
        mk(0, 8'h00, 0, 0, 0, 1, 2'b01, 8'h03, 1), // R4 edge_in ignored in width
        mk(0, 8'h00, 0, 0, 1, 0, 2'b01, 8'h13, 1), // R4 width_done sets
        mk(1, 8'h01, 0, 0, 0, 0, 2'b00, 8'h03, 1), // R4 clear
        mk(0, 8'h00, 0, 0, 1, 0, 2'b10, 8'h03, 1), // R4 width_done ignored in period
        mk(0, 8'h00, 0, 0, 0, 1, 2'b10, 8'h13, 1), // R4 edge_in sets
        mk(1, 8'h01, 0, 0, 0, 1, 2'b10, 8'h13, 1), // R5 set beats clear
        mk(1, 8'h01, 0, 0, 0, 0, 2'b00, 8'h03, 1), // R4 clear
        mk(1, 8'h00, 0, 0, 1, 1, 2'b11, 8'h02, 1), // R6 stop pending, R4 mode 11 none
        mk(0, 8'h00, 1, 0, 0, 0, 2'b00, 8'h00, 0), // R6 tick applies stop
        mk(1, 8'h02, 1, 0, 0, 0, 2'b00, 8'h00, 0), // R7 status not writable
        mk(0, 8'h00, 0, 1, 0, 0, 2'b00, 8'h20, 0), // R3 set
        mk(1, 8'h00, 0, 1, 0, 0, 2'b00, 8'h20, 0), // R5 set beats clear
        mk(1, 8'h00, 0, 0, 0, 0, 2'b00, 8'h00, 0)  // R3 clear
    };

    // One cycle: drive at a negedge, let the posedge capture, return at the next negedge.
    task automatic step(input logic w, input logic [7:0] d, input logic t, input logic u,
                        input logic wd, input logic ei, input logic [1:0] m);
        bus_sel = w; bus_wr = w; bus_wdata = d; src_tick = t;
        evt_underflow = u; evt_width_done = wd; evt_edge_in = ei; meas_mode = m;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0; src_tick = 0;
        evt_underflow = 0; evt_width_done = 0; evt_edge_in = 0; meas_mode = 2'b00;
    endtask

    task automatic check(input string req, input logic [7:0] er, input logic ec);
        checks++;
        if (bus_rdata !== er || count_en !== ec) begin
            errors++;
            $display("FAIL %s: rdata=%02h count_en=%0b expected rdata=%02h count_en=%0b",
                     req, bus_rdata, count_en, er, ec);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", 8'h00, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 8'h00, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][23], VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12],
                 VEC[i][11], VEC[i][10:9]);
            check($sformatf("vector %0d (R3/R4/R5/R6/R7)", i), VEC[i][8:1], VEC[i][0]);
        end

        // R8: forced stop while running acts without a tick; R2 reads 0
        step(1, 8'h01, 0, 0, 0, 0, 2'b00);
        step(0, 8'h00, 1, 0, 0, 0, 2'b00);
        check("R8 running", 8'h03, 1);
        step(1, 8'h04, 0, 0, 0, 0, 2'b00);
        check("R8/R2 forced stop", 8'h00, 0);

        // R9: forced stop cancels a pending start
        step(1, 8'h01, 0, 0, 0, 0, 2'b00);
        step(1, 8'h04, 0, 0, 0, 0, 2'b00);
        step(0, 8'h00, 1, 0, 0, 0, 2'b00);
        step(0, 8'h00, 1, 0, 0, 0, 2'b00);
        check("R9 pending cancelled", 8'h00, 0);

        // R8: stop and start in one write, stop wins
        step(1, 8'h05, 1, 0, 0, 0, 2'b00);
        check("R8 stop overrides start", 8'h00, 0);
        step(0, 8'h00, 1, 0, 0, 0, 2'b00);
        check("R8 no run after tick", 8'h00, 0);

        // R6: tick coincident with the write does not apply it
        step(1, 8'h01, 1, 0, 0, 0, 2'b00);
        check("R6 coincident tick", 8'h01, 0);
        step(0, 8'h00, 0, 0, 0, 0, 2'b00);
        check("R6 no tick holds", 8'h01, 0);
        step(0, 8'h00, 1, 0, 0, 0, 2'b00);
        check("R6 later tick", 8'h03, 1);

        // R1: reset mid-operation returns to 0x00
        step(0, 8'h00, 0, 1, 1, 0, 2'b01);
        check("R3/R4 both flags", 8'h33, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 8'h00, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule